// File: doc/BRIEF.md
# Reset-Strapped Clock Ratio Generator

This block runs from the fast processor clock and derives a bus clock at one third, one quarter, one fifth or one sixth of that rate. It also provides a bus-clock enable pulse that marks each bus-clock rising position, a status clock at half the processor rate, and an active-low reset output for external peripherals.

The divide ratio comes from a three-bit strap field, which is driven on the low data bits while reset is held. The block keeps that ratio until the next reset. A control bit can hold the bus clock output low to save power, and the enable pulse keeps running while it does.

The reset input is asynchronous and active-low. Its release passes through a two-flop synchroniser before the divider starts. The reset output is released after a fixed number of bus periods, which models a lock delay.

Top module: `clk_ratio_gen`

## Requirements
- R1: The strap code sets the ratio N. The code 3'b011 selects 3, 3'b100 selects 4, 3'b101 selects 5 and 3'b110 selects 6. Every other code selects 4.
- R2: `bclk_o` repeats every N processor cycles. It is high for floor(N/2) cycles and low for the remaining cycles. The first high phase starts on the second rising `pclk` edge after `rst_n` rises.
- R3: `bclk_en` is high for exactly one processor cycle in every N cycles. That cycle is the first cycle of each `bclk_o` high phase.
- R4: The strap is captured only until the synchronised reset ends. A strap change after that has no effect on the ratio until the next reset.
- R5: `stclk_o` is 0 in reset. From the third rising edge after release, it inverts on every `pclk` rising edge.
- R6: While `bclk_off` is 1, `bclk_o` stays at 0. During that time `bclk_en` keeps its normal pattern.
- R7: Driving `rst_n` low forces `bclk_o`, `bclk_en`, `stclk_o` and `rst_out_n` to 0 at once, with no clock edge needed.
- R8: `rst_out_n` goes to 1 on the rising edge that follows the 16th `bclk_en` pulse. It then stays at 1 until `rst_n` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 3 | Ratio strap field taken from the low data bits |
| bclk_off | input | 1 | Control bit that holds the bus clock output low |
| bclk_o | output | 1 | Bus clock output |
| bclk_en | output | 1 | One-cycle pulse that marks each bus clock rising position |
| stclk_o | output | 1 | Status clock at half the processor rate |
| rst_out_n | output | 1 | Active-low reset for external devices |

## Verification
A wrong ratio register or a wrong divider count shows up at `bclk_o` and `bclk_en` within one bus period. The spacing between enable pulses no longer matches the strapped ratio, or the high phase has the wrong length.

A strap register that is not frozen after reset shows up at the first rising position after a mid-run strap change.

An error in the lock counter shows up only at the single cycle where `rst_out_n` should rise. For a ratio of 6, that cycle comes about ninety processor cycles after release, so the bench compares every cycle against an expected value.

// File: rtl/clk_ratio_gen.sv
`timescale 1ns/1ps
module clk_ratio_gen #(
  parameter int LOCK_PERIODS = 16
) (
  input  logic       pclk,
  input  logic       rst_n,
  input  logic [2:0] strap,
  input  logic       bclk_off,
  output logic       bclk_o,
  output logic       bclk_en,
  output logic       stclk_o,
  output logic       rst_out_n
);
  localparam int LW = $clog2(LOCK_PERIODS + 1);

  logic [1:0]    sync;
  logic          run;
  logic [2:0]    ratio;
  logic [2:0]    cnt;
  logic [LW-1:0] lock_cnt;

  function automatic logic [2:0] decode(input logic [2:0] s);
    case (s)
      3'd3, 3'd4, 3'd5, 3'd6: decode = s;
      default:                decode = 3'd4;
    endcase
  endfunction

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], 1'b1};

  assign run = sync[1];

  always_ff @(posedge pclk)
    if (!run) ratio <= decode(strap);

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n)                    cnt <= '0;
    else if (!run)                 cnt <= '0;
    else if (cnt == ratio - 3'd1)  cnt <= '0;
    else                           cnt <= cnt + 3'd1;

  assign bclk_en = run && (cnt == 3'd0);
  assign bclk_o  = run && !bclk_off && (cnt < (ratio >> 1));

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n)   stclk_o <= 1'b0;
    else if (run) stclk_o <= ~stclk_o;

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      lock_cnt  <= '0;
      rst_out_n <= 1'b0;
    end else if (bclk_en && !rst_out_n) begin
      lock_cnt <= lock_cnt + 1'b1;
      if (lock_cnt == LW'(LOCK_PERIODS - 1)) rst_out_n <= 1'b1;
    end
endmodule

module clk_ratio_gen_chk (
  input logic       pclk,
  input logic       rst_n,
  input logic       run,
  input logic [2:0] ratio,
  input logic       bclk_off,
  input logic       bclk_o,
  input logic       bclk_en,
  input logic       stclk_o,
  input logic       rst_out_n
);
  logic [3:0] gap;
  logic       seen;

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (bclk_en) begin
      gap  <= 4'd1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 4'd1;
    end

  // R3
  enable_period_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    bclk_en && seen |-> gap == {1'b0, ratio});

  // R1
  ratio_range_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    run |-> ratio >= 3'd3 && ratio <= 3'd6);

  // R4
  ratio_frozen_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    run && $past(run) |-> $stable(ratio));

  // R5
  status_toggle_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    rst_out_n && $past(rst_out_n) |-> stclk_o != $past(stclk_o));

  // R6
  bus_off_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    bclk_off |-> !bclk_o);

  // R8
  reset_out_hold_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    $past(rst_out_n) |-> rst_out_n);
endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .pclk(pclk), .rst_n(rst_n), .run(run), .ratio(ratio), .bclk_off(bclk_off),
  .bclk_o(bclk_o), .bclk_en(bclk_en), .stclk_o(stclk_o), .rst_out_n(rst_out_n)
);

// File: tb/test_clk_ratio_gen.sv
`timescale 1ns/1ps
module test_clk_ratio_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap = 3'd4;
  logic       bclk_off = 1'b0;
  logic       bclk_o, bclk_en, stclk_o, rst_out_n;
  int         checks = 0;
  int         failures = 0;
  logic [3:0] exp_q[$];

  always #2.5 clk = ~clk;

  clk_ratio_gen i_clk_ratio_gen (
    .pclk(clk), .rst_n(rst_n), .strap(strap), .bclk_off(bclk_off),
    .bclk_o(bclk_o), .bclk_en(bclk_en), .stclk_o(stclk_o), .rst_out_n(rst_out_n)
  );

  function automatic int ratio_of(input logic [2:0] s);
    if (s >= 3'd3 && s <= 3'd6) return int'(s);
    return 4;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check("R1/R2/R6 bclk_o", bclk_o, e[0]);
      check("R3 bclk_en", bclk_en, e[1]);
      check("R5 stclk_o", stclk_o, e[2]);
      check("R8 rst_out_n", rst_out_n, e[3]);
    end
  end

  task automatic run_case(input logic [2:0] s, input logic off, input logic late_change);
    int n, m;
    rst_n = 1'b0;
    #1;
    // R7
    check("R7 bclk_o async", bclk_o, 1'b0);
    check("R7 bclk_en async", bclk_en, 1'b0);
    check("R7 stclk_o async", stclk_o, 1'b0);
    check("R7 rst_out_n async", rst_out_n, 1'b0);
    strap = s;
    bclk_off = off;
    repeat (4) @(negedge clk);
    #1;
    rst_n = 1'b1;
    n = ratio_of(s);
    m = 3 + 15 * n + 2 * n;
    for (int j = 1; j <= m; j++) begin
      logic b, en, st, ro;
      b  = (j >= 2) && !off && (((j - 2) % n) < (n / 2));
      en = (j >= 2) && (((j - 2) % n) == 0);
      st = (j >= 2) && (j % 2 == 1);
      ro = (j >= 3 + 15 * n);
      exp_q.push_back({ro, st, en, b});
    end
    if (late_change) begin
      // R4: strap moves after start; expectations keep the captured ratio
      repeat (10) @(negedge clk);
      strap = 3'b011;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #1;
    check("R7 reset bclk_o", bclk_o, 1'b0);
    check("R7 reset rst_out_n", rst_out_n, 1'b0);
    repeat (3) @(negedge clk);
    run_case(3'b011, 1'b0, 1'b0);  // R1 ratio 3
    run_case(3'b100, 1'b0, 1'b0);  // R1 ratio 4
    run_case(3'b101, 1'b0, 1'b0);  // R1 ratio 5
    run_case(3'b110, 1'b0, 1'b0);  // R1 ratio 6
    run_case(3'b000, 1'b0, 1'b0);  // R1 fallback
    run_case(3'b111, 1'b0, 1'b0);  // R1 fallback
    run_case(3'b110, 1'b0, 1'b1);  // R4 late strap change
    run_case(3'b101, 1'b1, 1'b0);  // R6 bus clock off
    run_case(3'b011, 1'b1, 1'b1);  // R4 and R6 together
    rst_n = 1'b0;
    #1;
    check("R7 final rst_out_n", rst_out_n, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule